// File: doc/BRIEF.md
# Reservation Station Pool with Broadcast Wakeup

This block sits in front of a single floating-point execution unit and holds instructions until their operands are ready. An issue port delivers an opcode and two source operands. Each operand is either a ready value or the tag of the station that will produce it. An accepted instruction is written into the lowest-numbered free station. A station's number, counted from 1, is its tag. Tag 0 is reserved to mean "value present".

The execution unit is a fixed-latency stub. Its output is the single result bus, which carries a valid bit, a tag and a value. Every busy station watches this bus. A station that waits on the broadcast tag copies the value and clears its wait tag, so any number of stations can wake in the same cycle. A station whose two tags are both zero is ready. The lowest-numbered ready station is sent to the unit and marked as executing. When a station's own result appears on the bus, the station is released.

The issue side sees a structural stall while every station is occupied. A broadcast that lands in the same cycle as an issue naming that tag is folded into the newly written station.

Top module: `rsv_station_pool`

## Requirements
- R1: While reset is held, and in the first cycle after it, no station is busy, `iss_ready` is 1, `iss_tag` is 1, and `disp_valid` and `cdb_valid` are 0.
- R2: An issue is accepted on a rising edge where `iss_valid` and `iss_ready` are both 1. It is placed in the lowest-numbered free station. `iss_tag` always shows that station's tag, counting stations from 1.
- R3: When all stations are busy, `iss_ready` is 0. An issue offered in that state is ignored: it never produces a dispatch or a broadcast.
- R4: An operand tag of 0 means the value given with it is used as-is, or that the operand is unused. An instruction issued with both tags 0 shows `disp_valid`=1 with its own tag on `disp_tag` in the cycle after acceptance.
- R5: A station's result appears with `cdb_valid`=1 exactly FU_LAT cycles after the cycle in which it was dispatched. `cdb_tag` is the station's tag. `cdb_data` is the opcode applied modulo 2^32, with these encodings: 0 is a+b, 1 is a-b, 2 is a XOR b, and 3 passes a.
- R6: Every busy station whose nonzero wait tag equals a valid broadcast tag captures `cdb_data` and clears that tag in the same cycle. This holds for any number of stations at once. Such a station can be dispatched in the following cycle.
- R7: When several stations are ready, the lowest-numbered one is dispatched. A dispatched station is not dispatched again, and the next ready station is dispatched in the following cycle.
- R8: A station is released at the end of the cycle that carries its own broadcast. In the next cycle it is free for issue.
- R9: If an issue names a tag that is on the valid result bus in that same cycle, the new station captures the broadcast value at issue. It can be dispatched in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| iss_valid | input | 1 | Issue request |
| iss_op | input | 2 | Opcode (0 add, 1 sub, 2 xor, 3 pass a) |
| iss_qa | input | 2 | Producer tag for operand a, 0 means ready |
| iss_va | input | 32 | Value of operand a when its tag is 0 |
| iss_qb | input | 2 | Producer tag for operand b, 0 means ready or unused |
| iss_vb | input | 32 | Value of operand b when its tag is 0 |
| iss_ready | output | 1 | At least one station is free |
| iss_tag | output | 2 | Tag the next accepted issue receives |
| disp_valid | output | 1 | A station is dispatched in this cycle |
| disp_tag | output | 2 | Tag of the dispatched station |
| cdb_valid | output | 1 | Result bus carries a result |
| cdb_tag | output | 2 | Tag of the producing station |
| cdb_data | output | 32 | Result value |

## Verification
Each result has a fixed timing. A dispatch shows in the cycle after the edge that accepts a ready instruction. The broadcast follows FU_LAT cycles after the dispatch cycle. The station is free again one cycle after that, and a woken waiter is dispatched in the cycle after the broadcast. The bench drives and samples only on falling edges and counts falling edges from the accepting edge. Each check is placed in the exact cycle where the result is due, and the cycles around it are also checked where an early or late event would matter. This covers the order in which two waiters are dispatched after they wake together, and the cycles where a rejected issue would otherwise show up.

// File: rtl/rsp_pkg.sv
`timescale 1ns/1ps
package rsp_pkg;

  localparam int unsigned RSP_NUM_ST = 3;
  localparam int unsigned RSP_DATA_W = 32;
  localparam int unsigned RSP_OP_W   = 2;
  localparam int unsigned RSP_TAG_W  = $clog2(RSP_NUM_ST + 1);

  typedef logic [RSP_DATA_W-1:0] word_t;
  typedef logic [RSP_TAG_W-1:0]  tag_t;

  typedef enum logic [RSP_OP_W-1:0] {
    FU_ADD  = 2'd0,
    FU_SUB  = 2'd1,
    FU_XOR  = 2'd2,
    FU_PASS = 2'd3
  } fu_op_e;

  // one source operand: wait tag plus value, value valid when q is zero
  typedef struct packed {
    tag_t  q;
    word_t v;
  } opnd_t;

  // arithmetic of the execution stub
  function automatic word_t fu_calc(fu_op_e op, word_t a, word_t b);
    word_t r;
    case (op)
      FU_ADD:  r = a + b;
      FU_SUB:  r = a - b;
      FU_XOR:  r = a ^ b;
      default: r = a;
    endcase
    return r;
  endfunction

  // operand snoop against the result bus
  function automatic opnd_t snoop(opnd_t cur, logic bus_v, tag_t bus_t, word_t bus_d);
    opnd_t r;
    r = cur;
    if (bus_v && (cur.q != '0) && (cur.q == bus_t)) begin
      r.q = '0;
      r.v = bus_d;
    end
    return r;
  endfunction

  // station index to tag (tags start at 1)
  function automatic tag_t slot_tag(int unsigned idx);
    return tag_t'(idx + 1);
  endfunction

endpackage

// File: rtl/rsp_pick.sv
`timescale 1ns/1ps
module rsp_pick #(
  parameter int unsigned N = 3
) (
  input  logic [N-1:0] req,
  output logic [N-1:0] gnt,
  output logic         any
);

  // lowest index wins
  always_comb begin
    logic taken;
    taken = 1'b0;
    for (int i = 0; i < N; i++) begin
      gnt[i] = req[i] & ~taken;
      taken  = taken | req[i];
    end
    any = taken;
  end

endmodule

// File: rtl/rsp_entry.sv
`timescale 1ns/1ps
module rsp_entry
  import rsp_pkg::*;
#(
  parameter int unsigned MY_IDX = 0
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   alloc,
  input  logic   launch,
  input  fu_op_e iss_op,
  input  opnd_t  iss_a,
  input  opnd_t  iss_b,
  input  logic   bus_v,
  input  tag_t   bus_t,
  input  word_t  bus_d,
  output logic   busy,
  output logic   exec,
  output logic   ready,
  output logic   retire,
  output fu_op_e op,
  output opnd_t  a,
  output opnd_t  b
);

  localparam tag_t MY_TAG = slot_tag(MY_IDX);

  assign ready  = busy & ~exec & (a.q == '0) & (b.q == '0);
  assign retire = busy & bus_v & (bus_t == MY_TAG);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      exec <= 1'b0;
      op   <= FU_ADD;
      a    <= '0;
      b    <= '0;
    end else if (alloc) begin
      busy <= 1'b1;
      exec <= 1'b0;
      op   <= iss_op;
      a    <= snoop(iss_a, bus_v, bus_t, bus_d);
      b    <= snoop(iss_b, bus_v, bus_t, bus_d);
    end else if (busy) begin
      if (retire) begin
        busy <= 1'b0;
        exec <= 1'b0;
      end else if (launch) begin
        exec <= 1'b1;
      end
      a <= snoop(a, bus_v, bus_t, bus_d);
      b <= snoop(b, bus_v, bus_t, bus_d);
    end
  end

endmodule

// File: rtl/rsp_fu_stub.sv
`timescale 1ns/1ps
module rsp_fu_stub
  import rsp_pkg::*;
#(
  parameter int unsigned LAT = 3
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   start,
  input  tag_t   start_tag,
  input  fu_op_e op,
  input  word_t  opa,
  input  word_t  opb,
  output logic   out_v,
  output tag_t   out_t,
  output word_t  out_d
);

  logic [LAT-1:0] v_q;
  tag_t           t_q [LAT];
  word_t          d_q [LAT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_q <= '0;
      for (int i = 0; i < LAT; i++) begin
        t_q[i] <= '0;
        d_q[i] <= '0;
      end
    end else begin
      v_q[0] <= start;
      t_q[0] <= start_tag;
      d_q[0] <= fu_calc(op, opa, opb);
      for (int i = 1; i < LAT; i++) begin
        v_q[i] <= v_q[i-1];
        t_q[i] <= t_q[i-1];
        d_q[i] <= d_q[i-1];
      end
    end
  end

  assign out_v = v_q[LAT-1];
  assign out_t = t_q[LAT-1];
  assign out_d = d_q[LAT-1];

endmodule

// File: rtl/rsv_station_pool.sv
`timescale 1ns/1ps
module rsv_station_pool
  import rsp_pkg::*;
#(
  parameter int unsigned FU_LAT = 3
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  iss_valid,
  input  logic [RSP_OP_W-1:0]   iss_op,
  input  logic [RSP_TAG_W-1:0]  iss_qa,
  input  logic [RSP_DATA_W-1:0] iss_va,
  input  logic [RSP_TAG_W-1:0]  iss_qb,
  input  logic [RSP_DATA_W-1:0] iss_vb,
  output logic                  iss_ready,
  output logic [RSP_TAG_W-1:0]  iss_tag,
  output logic                  disp_valid,
  output logic [RSP_TAG_W-1:0]  disp_tag,
  output logic                  cdb_valid,
  output logic [RSP_TAG_W-1:0]  cdb_tag,
  output logic [RSP_DATA_W-1:0] cdb_data
);

  localparam int unsigned N  = RSP_NUM_ST;
  localparam int unsigned TW = RSP_TAG_W;

  // named internal events (observed by the checker)
  logic [N-1:0]    st_busy;
  logic [N-1:0]    st_exec;
  logic [N-1:0]    st_ready;
  logic [N-1:0]    st_retire;
  logic [N-1:0]    alloc_gnt;
  logic [N-1:0]    disp_gnt;
  logic [N*TW-1:0] st_qa_flat;
  logic [N*TW-1:0] st_qb_flat;
  logic            free_any;
  logic            issue_fire;

  fu_op_e st_op [N];
  opnd_t  st_a  [N];
  opnd_t  st_b  [N];

  opnd_t  in_a, in_b;
  fu_op_e in_op;

  fu_op_e sel_op;
  word_t  sel_va, sel_vb;

  logic   bus_v;
  tag_t   bus_t;
  word_t  bus_d;

  assign in_a       = '{q: iss_qa, v: iss_va};
  assign in_b       = '{q: iss_qb, v: iss_vb};
  assign in_op      = fu_op_e'(iss_op);
  assign issue_fire = iss_valid & free_any;
  assign iss_ready  = free_any;

  rsp_pick #(.N(N)) u_alloc_pick (
    .req (~st_busy),
    .gnt (alloc_gnt),
    .any (free_any)
  );

  rsp_pick #(.N(N)) u_disp_pick (
    .req (st_ready),
    .gnt (disp_gnt),
    .any (disp_valid)
  );

  for (genvar g = 0; g < N; g++) begin : g_st
    rsp_entry #(.MY_IDX(g)) u_ent (
      .clk    (clk),
      .rst_n  (rst_n),
      .alloc  (issue_fire & alloc_gnt[g]),
      .launch (disp_gnt[g]),
      .iss_op (in_op),
      .iss_a  (in_a),
      .iss_b  (in_b),
      .bus_v  (bus_v),
      .bus_t  (bus_t),
      .bus_d  (bus_d),
      .busy   (st_busy[g]),
      .exec   (st_exec[g]),
      .ready  (st_ready[g]),
      .retire (st_retire[g]),
      .op     (st_op[g]),
      .a      (st_a[g]),
      .b      (st_b[g])
    );
    assign st_qa_flat[g*TW +: TW] = st_a[g].q;
    assign st_qb_flat[g*TW +: TW] = st_b[g].q;
  end

  // one-hot encode and operand mux
  always_comb begin
    logic [RSP_OP_W-1:0] op_acc;
    iss_tag  = '0;
    disp_tag = '0;
    op_acc   = '0;
    sel_va   = '0;
    sel_vb   = '0;
    for (int i = 0; i < N; i++) begin
      if (alloc_gnt[i]) iss_tag = iss_tag | slot_tag(i);
      if (disp_gnt[i]) begin
        disp_tag = disp_tag | slot_tag(i);
        op_acc   = op_acc | st_op[i];
        sel_va   = sel_va | st_a[i].v;
        sel_vb   = sel_vb | st_b[i].v;
      end
    end
    sel_op = fu_op_e'(op_acc);
  end

  rsp_fu_stub #(.LAT(FU_LAT)) u_fu (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (disp_valid),
    .start_tag (disp_tag),
    .op        (sel_op),
    .opa       (sel_va),
    .opb       (sel_vb),
    .out_v     (bus_v),
    .out_t     (bus_t),
    .out_d     (bus_d)
  );

  assign cdb_valid = bus_v;
  assign cdb_tag   = bus_t;
  assign cdb_data  = bus_d;

endmodule

// File: rtl/rsp_pool_chk.sv
`timescale 1ns/1ps
module rsp_pool_chk #(
  parameter int unsigned N  = 3,
  parameter int unsigned TW = 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic          iss_ready,
  input logic [N-1:0]  st_busy,
  input logic [N-1:0]  st_exec,
  input logic          disp_valid,
  input logic [N-1:0]  disp_gnt,
  input logic          cdb_valid,
  input logic [TW-1:0] cdb_tag,
  input logic [N*TW-1:0] st_qa_flat,
  input logic [N*TW-1:0] st_qb_flat
);

  logic [N-1:0] cdb_hot;
  always_comb begin
    cdb_hot = '0;
    for (int i = 0; i < N; i++)
      if (cdb_valid && (cdb_tag == TW'(i + 1))) cdb_hot[i] = 1'b1;
  end

  assert_reset_idle_R1: assert property (@(posedge clk)
    !rst_n |=> (st_busy == '0) && !cdb_valid);

  assert_full_stalls_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (&st_busy) |-> !iss_ready);

  assert_disp_onehot_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(disp_gnt) && (disp_valid == (disp_gnt != '0)));

  assert_launch_marks_R7: assert property (@(posedge clk) disable iff (!rst_n)
    disp_valid |=> (($past(disp_gnt) & st_exec) != '0));

  assert_bus_owner_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cdb_valid |-> ((cdb_hot & st_busy & st_exec) == cdb_hot) && (cdb_hot != '0));

  assert_free_on_bcast_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cdb_valid |=> (($past(cdb_hot) & st_busy) == '0));

  // R6 and R9: no busy station still waits on a tag that was just broadcast
  for (genvar g = 0; g < N; g++) begin : g_wake
    assert_wake_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
      cdb_valid |=> (!st_busy[g] ||
        ((st_qa_flat[g*TW +: TW] != $past(cdb_tag)) &&
         (st_qb_flat[g*TW +: TW] != $past(cdb_tag)))));
  end

endmodule

bind rsv_station_pool rsp_pool_chk #(
  .N  (rsp_pkg::RSP_NUM_ST),
  .TW (rsp_pkg::RSP_TAG_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .iss_ready  (iss_ready),
  .st_busy    (st_busy),
  .st_exec    (st_exec),
  .disp_valid (disp_valid),
  .disp_gnt   (disp_gnt),
  .cdb_valid  (cdb_valid),
  .cdb_tag    (cdb_tag),
  .st_qa_flat (st_qa_flat),
  .st_qb_flat (st_qb_flat)
);

// File: tb/rsv_station_pool_tb.sv
`timescale 1ns/1ps
module rsv_station_pool_tb;

  localparam int LAT = 3;
  localparam int NV  = 6;
  // {op[97:96], a[95:64], b[63:32], expected[31:0]}
  localparam logic [97:0] VEC [NV] = '{
    {2'd0, 32'h0000_0010, 32'h0000_0022, 32'h0000_0032},
    {2'd0, 32'hFFFF_FFFF, 32'h0000_0001, 32'h0000_0000},
    {2'd1, 32'd100,       32'd1,         32'd99},
    {2'd1, 32'h0000_0000, 32'h0000_0001, 32'hFFFF_FFFF},
    {2'd2, 32'h0000_F0F0, 32'h0000_0FF0, 32'h0000_FF00},
    {2'd3, 32'h0000_ABCD, 32'h0000_1234, 32'h0000_ABCD}
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic        iss_valid;
  logic [1:0]  iss_op;
  logic [1:0]  iss_qa;
  logic [31:0] iss_va;
  logic [1:0]  iss_qb;
  logic [31:0] iss_vb;
  logic        iss_ready;
  logic [1:0]  iss_tag;
  logic        disp_valid;
  logic [1:0]  disp_tag;
  logic        cdb_valid;
  logic [1:0]  cdb_tag;
  logic [31:0] cdb_data;

  int n_chk  = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  rsv_station_pool #(.FU_LAT(LAT)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .iss_valid(iss_valid), .iss_op(iss_op),
    .iss_qa(iss_qa), .iss_va(iss_va), .iss_qb(iss_qb), .iss_vb(iss_vb),
    .iss_ready(iss_ready), .iss_tag(iss_tag),
    .disp_valid(disp_valid), .disp_tag(disp_tag),
    .cdb_valid(cdb_valid), .cdb_tag(cdb_tag), .cdb_data(cdb_data)
  );

  task automatic nxt();
    @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic drive(input logic v, input logic [1:0] op, input logic [1:0] qa,
                       input logic [31:0] va, input logic [1:0] qb, input logic [31:0] vb);
    iss_valid = v; iss_op = op; iss_qa = qa; iss_va = va; iss_qb = qb; iss_vb = vb;
  endtask

  task automatic idle(input int n);
    drive(1'b0, 2'd0, 2'd0, 32'd0, 2'd0, 32'd0);
    repeat (n) nxt();
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    bit quiet;
    rst_n = 1'b0;
    drive(1'b0, 2'd0, 2'd0, 32'd0, 2'd0, 32'd0);
    repeat (3) nxt();
    // R1 during reset
    chk(iss_ready === 1'b1 && iss_tag === 2'd1, "R1 reset ready/tag", {30'd0, iss_tag}, 32'd1);
    chk(disp_valid === 1'b0 && cdb_valid === 1'b0, "R1 reset idle", {30'd0, disp_valid, cdb_valid}, 32'd0);
    rst_n = 1'b1;
    nxt();
    chk(iss_ready === 1'b1 && disp_valid === 1'b0 && cdb_valid === 1'b0, "R1 after reset",
        {29'd0, iss_ready, disp_valid, cdb_valid}, 32'd4);

    // table: one ready instruction at a time (R2 R4 R5 R8)
    for (int i = 0; i < NV; i++) begin
      drive(1'b1, VEC[i][97:96], 2'd0, VEC[i][95:64], 2'd0, VEC[i][63:32]);
      chk(iss_tag === 2'd1, "R2 lowest free", {30'd0, iss_tag}, 32'd1);
      nxt();
      drive(1'b0, 2'd0, 2'd0, 32'd0, 2'd0, 32'd0);
      chk(disp_valid === 1'b1 && disp_tag === 2'd1, "R4 dispatch next cycle", {30'd0, disp_tag}, 32'd1);
      chk(iss_tag === 2'd2, "R2 next free", {30'd0, iss_tag}, 32'd2);
      repeat (LAT - 1) begin
        nxt();
        chk(cdb_valid === 1'b0, "R5 not early", {31'd0, cdb_valid}, 32'd0);
      end
      nxt();
      chk(cdb_valid === 1'b1 && cdb_tag === 2'd1, "R5 bcast tag", {30'd0, cdb_tag}, 32'd1);
      chk(cdb_data === VEC[i][31:0], "R5 bcast data", cdb_data, VEC[i][31:0]);
      nxt();
      chk(iss_tag === 2'd1 && cdb_valid === 1'b0, "R8 freed", {30'd0, iss_tag}, 32'd1);
      idle(2);
    end

    // wakeup of two waiters, priority, stall (R2 R3 R6 R7 R8)
    drive(1'b1, 2'd0, 2'd0, 32'd5, 2'd0, 32'd7);          // A -> tag1
    nxt();
    chk(iss_tag === 2'd2, "R2 second slot", {30'd0, iss_tag}, 32'd2);
    drive(1'b1, 2'd1, 2'd1, 32'd0, 2'd0, 32'd10);         // B = A - 10 -> tag2
    nxt();
    chk(iss_tag === 2'd3, "R2 third slot", {30'd0, iss_tag}, 32'd3);
    drive(1'b1, 2'd0, 2'd0, 32'd100, 2'd1, 32'd0);        // C = 100 + A -> tag3
    nxt();
    chk(iss_ready === 1'b0, "R3 full stalls", {31'd0, iss_ready}, 32'd0);
    drive(1'b1, 2'd0, 2'd0, 32'h55, 2'd0, 32'h1);         // D offered while full
    nxt();
    chk(cdb_valid === 1'b1 && cdb_tag === 2'd1 && cdb_data === 32'd12, "R5 producer bcast", cdb_data, 32'd12);
    chk(disp_valid === 1'b0, "R6 waiters not ready before bcast", {31'd0, disp_valid}, 32'd0);
    chk(iss_ready === 1'b0, "R3 still full", {31'd0, iss_ready}, 32'd0);
    nxt();
    drive(1'b0, 2'd0, 2'd0, 32'd0, 2'd0, 32'd0);
    chk(disp_valid === 1'b1 && disp_tag === 2'd2, "R6 R7 woken lowest first", {30'd0, disp_tag}, 32'd2);
    chk(iss_ready === 1'b1 && iss_tag === 2'd1, "R8 producer slot free", {30'd0, iss_tag}, 32'd1);
    nxt();
    chk(disp_valid === 1'b1 && disp_tag === 2'd3, "R6 R7 second waiter next", {30'd0, disp_tag}, 32'd3);
    nxt();
    chk(disp_valid === 1'b0, "R7 no redispatch", {31'd0, disp_valid}, 32'd0);
    nxt();
    chk(cdb_valid === 1'b1 && cdb_tag === 2'd2 && cdb_data === 32'd2, "R6 waiter a result", cdb_data, 32'd2);
    nxt();
    chk(cdb_valid === 1'b1 && cdb_tag === 2'd3 && cdb_data === 32'd112, "R6 waiter b result", cdb_data, 32'd112);
    quiet = 1'b1;
    for (int k = 0; k < 6; k++) begin
      nxt();
      if (cdb_valid !== 1'b0 || disp_valid !== 1'b0) quiet = 1'b0;
    end
    chk(quiet, "R3 rejected issue left no trace", {31'd0, quiet}, 32'd1);
    chk(iss_tag === 2'd1 && iss_ready === 1'b1, "R3 R8 pool empty", {30'd0, iss_tag}, 32'd1);

    // same-cycle bypass (R9)
    drive(1'b1, 2'd0, 2'd0, 32'd4, 2'd0, 32'd5);          // P -> tag1
    nxt();
    drive(1'b0, 2'd0, 2'd0, 32'd0, 2'd0, 32'd0);
    repeat (LAT - 1) nxt();
    nxt();
    chk(cdb_valid === 1'b1 && cdb_tag === 2'd1 && cdb_data === 32'd9, "R9 producer on bus", cdb_data, 32'd9);
    chk(iss_tag === 2'd2, "R9 issue slot", {30'd0, iss_tag}, 32'd2);
    drive(1'b1, 2'd2, 2'd1, 32'd0, 2'd0, 32'd3);          // Q = P ^ 3 -> tag2
    nxt();
    drive(1'b0, 2'd0, 2'd0, 32'd0, 2'd0, 32'd0);
    chk(disp_valid === 1'b1 && disp_tag === 2'd2, "R9 captured at issue", {30'd0, disp_tag}, 32'd2);
    repeat (LAT - 1) nxt();
    nxt();
    chk(cdb_valid === 1'b1 && cdb_tag === 2'd2 && cdb_data === 32'd10, "R9 bypass result", cdb_data, 32'd10);
    idle(3);

    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

endmodule